// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block supplies stimulus vectors to a circuit under test during built-in self test. It keeps the switching activity at the circuit's inputs lower than a plain shift-register generator would. A maximal-length Fibonacci shift register holds the current random vector and produces the next one. Between these two vectors the block does not jump in one step. It walks across four equal bit groups, one group per clock. After three intermediate vectors the fourth step lands on the full next vector. That vector then becomes the current one.

The register is seeded through a load strobe. A zero seed would lock the register, so it is replaced by the value 1. After seeding, the enable input alone advances the walk, one output vector per clock. When enable is low, the output and all internal state are frozen.

Top module: `lowtog_tpg`

## Requirements
- R1: While the synchronous active-high reset is applied, pattern_out takes the reset seed value 8'h01 and pattern_valid goes low. The register state and the step position become seed 8'h01, step 1.
- R2: When seed_load is high at a clock edge, pattern_out shows the seed after that edge and pattern_valid goes low. The walk then restarts at step 1 from that seed.
- R3: A seed_load with seed_value equal to zero loads 8'h01 instead, and pattern_out then shows 8'h01.
- R4: Bits [2g+1:2g] form group g, for g = 0..3. On step k (k = 1, 2, 3), the output takes groups 0..k-1 from the next register vector and the other groups from the current vector.
- R5: On step 4 the output is the whole next vector. That vector becomes the current vector, and the following enabled clock is step 1 again.
- R6: The next vector of state s is {s[6:0], s[7]^s[5]^s[4]^s[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. From any nonzero seed, the current vector returns to the seed after exactly 255 advances (1020 enabled clocks).
- R7: Two consecutive values of pattern_out never differ in more than one bit group, while pattern_valid is high.
- R8: A clock edge with enable low and seed_load low leaves pattern_out and the walk position unchanged, and pattern_valid goes low.
- R9: pattern_valid is high after every clock edge at which enable was high and seed_load was low.
- R10: seed_load takes priority over enable when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Strobe that loads seed_value into the register |
| seed_value | input | WIDTH | Seed to load (zero is replaced by 1) |
| enable | input | 1 | Advance the walk by one step per clock |
| pattern_out | output | WIDTH | Registered vector for the circuit under test |
| pattern_valid | output | 1 | High after each clock that produced a new vector |

## Verification
The hardest conditions to reach from the ports involve the step position, which is never visible directly. The first is a reload or a pause that lands on each of the four steps. The second is the return of the register to its seed after the full 255-vector period. The stimulus loads a seed and advances through each step position in turn. At each position it pauses, resumes, and reloads, then compares every output against an arithmetic model of the group walk. A separate phase runs one unbroken 1020-clock sweep and checks that the output comes back to the seed exactly at the end.

// File: rtl/lowtog_pkg.sv
package lowtog_pkg;
  localparam int STEPS = 4;
  localparam int PHASE_W = $clog2(STEPS);

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } act_t;
endpackage

// File: rtl/lowtog_lfsr.sv
module lowtog_lfsr #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] BOOT = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             advance,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] load_val
);
  logic [WIDTH-1:0] state;
  logic             fb;

  assign load_val = (seed == '0) ? WIDTH'(1) : seed;
  assign fb       = ^(state & TAPS);
  assign nxt      = {state[WIDTH-2:0], fb};
  assign cur      = state;

  always_ff @(posedge clk) begin
    if (rst)          state <= BOOT;
    else if (load)    state <= load_val;
    else if (advance) state <= nxt;
  end
endmodule

// File: rtl/lowtog_seq.sv
module lowtog_seq
  import lowtog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               enable,
  output act_t               act,
  output logic [PHASE_W-1:0] phase,
  output logic               advance
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(STEPS - 1);

  always_comb begin
    if (load)        act = ACT_LOAD;
    else if (enable) act = ACT_STEP;
    else             act = ACT_HOLD;
  end

  assign advance = (act == ACT_STEP) && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else begin
      case (act)
        ACT_LOAD: phase <= '0;
        ACT_STEP: phase <= advance ? '0 : phase + 1'b1;
        default:  phase <= phase;
      endcase
    end
  end
endmodule

// File: rtl/lowtog_blend.sv
module lowtog_blend
  import lowtog_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   nxt,
  input  logic [PHASE_W-1:0] phase,
  output logic [WIDTH-1:0]   mix
);
  localparam int GW = WIDTH / STEPS;

  for (genvar g = 0; g < STEPS; g++) begin : g_grp
    assign mix[g*GW +: GW] = (PHASE_W'(g) <= phase) ? nxt[g*GW +: GW]
                                                   : cur[g*GW +: GW];
  end
endmodule

// File: rtl/lowtog_tpg.sv
module lowtog_tpg
  import lowtog_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'hB8,
  parameter logic [WIDTH-1:0] RESET_SEED = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_value,
  input  logic             enable,
  output logic [WIDTH-1:0] pattern_out,
  output logic             pattern_valid
);
  localparam logic [WIDTH-1:0] BOOT = (RESET_SEED == '0) ? WIDTH'(1) : RESET_SEED;

  act_t               act;
  logic [PHASE_W-1:0] phase;
  logic               advance;
  logic [WIDTH-1:0]   cur, nxt, load_val, mix;

  lowtog_seq u_seq (
    .clk(clk), .rst(rst), .load(seed_load), .enable(enable),
    .act(act), .phase(phase), .advance(advance)
  );

  lowtog_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .BOOT(BOOT)) u_lfsr (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_value),
    .advance(advance), .cur(cur), .nxt(nxt), .load_val(load_val)
  );

  lowtog_blend #(.WIDTH(WIDTH)) u_blend (
    .cur(cur), .nxt(nxt), .phase(phase), .mix(mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern_out   <= BOOT;
      pattern_valid <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          pattern_out   <= load_val;
          pattern_valid <= 1'b0;
        end
        ACT_STEP: begin
          pattern_out   <= mix;
          pattern_valid <= 1'b1;
        end
        default: pattern_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lowtog_chk.sv
module lowtog_chk
  import lowtog_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_value,
  input logic             enable,
  input logic [WIDTH-1:0] pattern_out,
  input logic             pattern_valid
);
  localparam int GW = WIDTH / STEPS;

  logic [WIDTH-1:0] prev;
  logic             armed;
  logic [STEPS-1:0] grp_diff;

  always_ff @(posedge clk) begin
    prev  <= pattern_out;
    armed <= !rst;
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_diff
    assign grp_diff[g] = |(pattern_out[g*GW +: GW] ^ prev[g*GW +: GW]);
  end

  // R7
  a_r7_one_group: assert property (@(posedge clk) disable iff (rst)
    (armed && pattern_valid) |-> ($countones(grp_diff) <= 1));

  // R2 and R3
  a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
    ($past(seed_load) && !$past(rst)) |->
      (!pattern_valid && pattern_out ==
        (($past(seed_value) == '0) ? WIDTH'(1) : $past(seed_value))));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) && !$past(seed_load) && !$past(rst)) |->
      ($stable(pattern_out) && !pattern_valid));

  // R9
  a_r9_valid: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(seed_load) && !$past(rst)) |-> pattern_valid);

  // R10
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && $past(seed_load) && !$past(rst)) |-> !pattern_valid);
endmodule

bind lowtog_tpg lowtog_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
  .enable(enable), .pattern_out(pattern_out), .pattern_valid(pattern_valid)
);

// File: tb/lowtog_tpg_bench.sv
module lowtog_tpg_bench;
  localparam int W = 8;
  localparam int GW = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         seed_load = 1'b0;
  logic [W-1:0] seed_value = '0;
  logic         enable = 1'b0;
  logic [W-1:0] pattern_out;
  logic         pattern_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_cur, m_out, m_prev;
  int           m_phase;
  logic         m_valid;

  lowtog_tpg u_lowtog_tpg (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .enable(enable), .pattern_out(pattern_out), .pattern_valid(pattern_valid)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] nextv(logic [W-1:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [W-1:0] walk(logic [W-1:0] c, logic [W-1:0] n, int k);
    logic [W-1:0] mask;
    mask = (k >= 4) ? {W{1'b1}} : W'((1 << (k * GW)) - 1);
    return (n & mask) | (c & ~mask);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic en, logic ld, logic [W-1:0] sd, string tag);
    logic [W-1:0] n;
    enable = en; seed_load = ld; seed_value = sd;
    @(posedge clk); #1;
    m_prev = m_out;
    if (ld) begin
      m_cur = (sd == 0) ? 8'h01 : sd; m_phase = 0; m_out = m_cur; m_valid = 0;
    end else if (en) begin
      n = nextv(m_cur);
      m_out = walk(m_cur, n, m_phase + 1); m_valid = 1;
      if (m_phase == 3) begin m_cur = n; m_phase = 0; end
      else m_phase++;
    end else m_valid = 0;
    chk(tag, pattern_out, m_out);
    chk(tag, W'(pattern_valid), W'(m_valid));
  endtask

  initial begin
    m_cur = 8'h01; m_out = 8'h01; m_phase = 0; m_valid = 0; m_prev = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pattern", pattern_out, 8'h01);
    chk("R1 reset valid", W'(pattern_valid), 8'h00);
    rst = 1'b0;

    for (int k = 1; k <= 4; k++) cyc(1, 0, 0, "R4 R5 walk from reset");
    chk("R6 first next vector", pattern_out, 8'h02);

    cyc(0, 1, 8'h5A, "R2 load seed");
    for (int i = 0; i < 1020; i++) begin
      int d;
      cyc(1, 0, 0, "R4 R5 R6 sweep");
      d = 0;
      for (int g = 0; g < 4; g++)
        if (((pattern_out ^ m_prev) >> (g * GW)) & 2'b11) d++;
      checks++;
      if (d > 1) begin
        errors++;
        $display("FAIL R7 groups changed actual %0d expected <=1", d);
      end
    end
    chk("R6 period 255", pattern_out, 8'h5A);

    cyc(0, 1, 8'h00, "R3 zero seed");
    chk("R3 zero seed value", pattern_out, 8'h01);

    for (int p = 0; p < 4; p++) begin
      cyc(0, 1, 8'hC3 ^ W'(p), "R2 reload");
      for (int i = 0; i < p; i++) cyc(1, 0, 0, "R4 pre-pause");
      cyc(0, 0, 8'hFF, "R8 hold");
      cyc(0, 0, 8'h00, "R8 hold");
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R9 resume");
      cyc(1, 1, 8'h3C, "R10 load wins");
      chk("R10 seed shown", pattern_out, 8'h3C);
      cyc(1, 0, 0, "R2 restart step 1");
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule